// File: doc/BRIEF.md
# TDMA Macrotick and Slot Timebase

This block is the time base of a node on a time-division shared bus. It divides the controller clock into macroticks and counts macroticks in a global time register. It then walks a static slot schedule against that time. Each table entry holds a slot length in macroticks and the ID of the node that owns the slot. A fixed number of slots makes a round. A fixed number of rounds makes a cluster cycle, and the cluster cycle repeats without end.

The host sees four one-clock strobes or flags: a macrotick strobe, a pulse when the global time wraps, a pulse at the start of every slot, and a transmit-window flag. The flag is high only while the local node owns the current slot. Clock-synchronisation logic elsewhere trims the time base through one signed correction input. The correction lengthens or shortens a single macrotick.

The schedule is written while the enable input is low and is then frozen. With enable high the schedule runs. Dropping enable freezes every counter in place.

Top module: `tdma_timebase`

## Requirements
- R1: With `en` high, `mtick` pulses for exactly one clock once every `MT_PERIOD` enabled clocks (default 20). The first pulse comes `MT_PERIOD` clocks after `en` rises following reset.
- R2: A one-clock `corr_req` with signed `corr_val` sets the length of the next macrotick to `MT_PERIOD + corr_val` clocks. The next macrotick is the one that begins at the next `mtick`. Later macroticks return to `MT_PERIOD`. Requests do not accumulate: the last one before that `mtick` wins.
- R3: `gtime` (`GT_W` bits, default 16) increments by one in the same clock in which `mtick` is high, and wraps modulo 2^GT_W.
- R4: `gt_ovf` is high for one clock exactly when `gtime` has just wrapped to 0, and never at any other time.
- R5: `slot_start` pulses for one clock, together with `mtick`, on the macrotick that begins each slot. The first slot begins on the first macrotick after enable. A slot whose length is L lasts L macroticks.
- R6: The table entry used is `round_idx*SLOTS + slot_idx`. `slot_idx` runs from 0 to SLOTS-1 and then returns to 0 while `round_idx` increments. After round ROUNDS-1 both indices return to 0, so the cluster cycle repeats.
- R7: `tx_window` is set at a slot start when that slot's owner equals `node_id` and is cleared at a slot start otherwise. It changes at no other time and is low before the first slot.
- R8: A table entry holds a nonzero length (`cfg_len`, LEN_W bits) and an owner (`cfg_owner`, NODE_W bits) at index `cfg_addr`. Writes are taken only while `en` is low. A write while `en` is high has no effect on the schedule.
- R9: While `en` is low, the microtick, macrotick and slot counters hold. `gtime` keeps its value and no `mtick` or `slot_start` is produced.
- R10: Synchronous active-high `rst` clears every output, the global time and the slot and round indices to 0. It does not clear the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (microtick) |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run the time base and the schedule |
| node_id | input | NODE_W | ID of the local node |
| corr_req | input | 1 | Strobe that takes a macrotick correction |
| corr_val | input | CORR_W | Signed correction in clocks |
| cfg_we | input | 1 | Table write strobe, honoured only with `en` low |
| cfg_addr | input | clog2(SLOTS*ROUNDS) | Table index being written |
| cfg_len | input | LEN_W | Slot length in macroticks, nonzero |
| cfg_owner | input | NODE_W | Owner node of the slot |
| mtick | output | 1 | Macrotick strobe |
| gtime | output | GT_W | Global time in macroticks |
| gt_ovf | output | 1 | Global time wrap pulse |
| slot_start | output | 1 | Start-of-slot pulse |
| tx_window | output | 1 | Local node may transmit |
| slot_idx | output | clog2(SLOTS) | Slot within the round |
| round_idx | output | clog2(ROUNDS) | Round within the cluster cycle |

## Verification
The bench builds a table with different slot lengths, including single-macrotick slots. A sequencer with an off-by-one in its length compare would therefore put every later slot start at the wrong global time. Corrections are sent both mid-macrotick and on the very clock of a macrotick boundary, and twice inside one macrotick. These cases expose a design that applies a correction to the wrong macrotick, adds requests together, or keeps the correction for more than one macrotick. The run goes past a global time wrap, which catches an overflow pulse that is misplaced or lasts two clocks. Enable is dropped mid-slot, and a table write is attempted while running. A design that keeps counting, or lets the write through, would shift or reassign the scoreboard's later slot starts.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
  localparam int LEN_W  = 8;
  localparam int NODE_W = 4;

  typedef struct packed {
    logic [LEN_W-1:0]  len;
    logic [NODE_W-1:0] owner;
  } slot_ent_t;
endpackage

// File: rtl/tdma_mtick_gen.sv
module tdma_mtick_gen #(
  parameter int PERIOD = 20,
  parameter int CORR_W = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic                     corr_req,
  input  logic signed [CORR_W-1:0] corr_val,
  output logic                     wrap,
  output logic                     mtick
);
  localparam int MAXLEN = PERIOD + (1 << (CORR_W - 1));
  localparam int CNT_W  = $clog2(MAXLEN + 1);

  logic [CNT_W-1:0]         cnt;
  logic [CNT_W-1:0]         cur_len;
  logic signed [CORR_W-1:0] pend;
  logic signed [CORR_W-1:0] take;
  logic signed [CNT_W+1:0]  nxt_len;

  always_comb begin
    take    = corr_req ? corr_val : pend;
    nxt_len = (CNT_W+2)'(PERIOD) + (CNT_W+2)'(take);
    wrap    = en && (cnt == cur_len - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      cur_len <= CNT_W'(PERIOD);
      pend    <= '0;
      mtick   <= 1'b0;
    end else begin
      mtick <= wrap;
      if (wrap) begin
        cnt     <= '0;
        cur_len <= nxt_len[CNT_W-1:0];
        pend    <= '0;
      end else begin
        if (en)       cnt  <= cnt + 1'b1;
        if (corr_req) pend <= corr_val;
      end
    end
  end

  assert_mtick_single_R1: assert property (@(posedge clk) disable iff (rst)
    mtick |=> !mtick);

  assert_len_floor_R2: assert property (@(posedge clk) disable iff (rst)
    cur_len >= CNT_W'(2));
endmodule

// File: rtl/tdma_gtime.sv
module tdma_gtime #(
  parameter int GT_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wrap,
  output logic [GT_W-1:0] gtime,
  output logic            ovf
);
  always_ff @(posedge clk) begin
    if (rst) begin
      gtime <= '0;
      ovf   <= 1'b0;
    end else begin
      ovf <= wrap && (gtime == '1);
      if (wrap) gtime <= gtime + 1'b1;
    end
  end

  assert_gt_step_R3: assert property (@(posedge clk) disable iff (rst)
    wrap |=> gtime == $past(gtime) + GT_W'(1));

  assert_ovf_zero_R4: assert property (@(posedge clk) disable iff (rst)
    ovf |-> gtime == '0);
endmodule

// File: rtl/tdma_slot_table.sv
module tdma_slot_table
  import tdma_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  slot_ent_t     cfg_ent,
  input  logic [AW-1:0] rd_a,
  input  logic [AW-1:0] rd_b,
  output slot_ent_t     ent_a,
  output slot_ent_t     ent_b
);
  slot_ent_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (cfg_we && !en && int'(cfg_addr) < DEPTH) mem[cfg_addr] <= cfg_ent;
  end

  assign ent_a = mem[rd_a];
  assign ent_b = mem[rd_b];

  assert_len_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_we |-> cfg_ent.len != '0);
endmodule

// File: rtl/tdma_slot_seq.sv
module tdma_slot_seq
  import tdma_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int ROUNDS = 2,
  localparam int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int RW    = (ROUNDS > 1) ? $clog2(ROUNDS) : 1,
  localparam int DEPTH = SLOTS * ROUNDS,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrap,
  input  logic [NODE_W-1:0] node_id,
  input  slot_ent_t         cur_ent,
  input  slot_ent_t         nxt_ent,
  output logic [AW-1:0]     addr_cur,
  output logic [AW-1:0]     addr_nxt,
  output logic              slot_start,
  output logic              tx_win,
  output logic [SW-1:0]     slot_idx,
  output logic [RW-1:0]     round_idx
);
  logic             started;
  logic [SW-1:0]    slot_q, slot_n;
  logic [RW-1:0]    rnd_q, rnd_n;
  logic [LEN_W-1:0] mcnt;
  logic             boundary;

  always_comb begin
    if (!started) begin
      slot_n = '0;
      rnd_n  = '0;
    end else if (slot_q == SW'(SLOTS - 1)) begin
      slot_n = '0;
      rnd_n  = (rnd_q == RW'(ROUNDS - 1)) ? '0 : rnd_q + 1'b1;
    end else begin
      slot_n = slot_q + 1'b1;
      rnd_n  = rnd_q;
    end
    addr_cur = AW'(int'(rnd_q) * SLOTS + int'(slot_q));
    addr_nxt = AW'(int'(rnd_n) * SLOTS + int'(slot_n));
    boundary = wrap && (!started || mcnt == cur_ent.len - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      started    <= 1'b0;
      slot_q     <= '0;
      rnd_q      <= '0;
      mcnt       <= '0;
      slot_start <= 1'b0;
      tx_win     <= 1'b0;
    end else begin
      slot_start <= boundary;
      if (boundary) begin
        started <= 1'b1;
        slot_q  <= slot_n;
        rnd_q   <= rnd_n;
        mcnt    <= '0;
        tx_win  <= (nxt_ent.owner == node_id);
      end else if (wrap) begin
        mcnt <= mcnt + 1'b1;
      end
    end
  end

  assign slot_idx  = slot_q;
  assign round_idx = rnd_q;

  assert_start_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    slot_start |-> $past(wrap));

  assert_tx_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !slot_start |-> $stable(tx_win));

  assert_idx_range_R6: assert property (@(posedge clk) disable iff (rst)
    (int'(slot_q) < SLOTS) && (int'(rnd_q) < ROUNDS));
endmodule

// File: rtl/tdma_timebase.sv
module tdma_timebase
  import tdma_pkg::*;
#(
  parameter int MT_PERIOD = 20,
  parameter int CORR_W    = 5,
  parameter int GT_W      = 16,
  parameter int SLOTS     = 4,
  parameter int ROUNDS    = 2,
  localparam int SW       = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int RW       = (ROUNDS > 1) ? $clog2(ROUNDS) : 1,
  localparam int DEPTH    = SLOTS * ROUNDS,
  localparam int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic [NODE_W-1:0]        node_id,
  input  logic                     corr_req,
  input  logic signed [CORR_W-1:0] corr_val,
  input  logic                     cfg_we,
  input  logic [AW-1:0]            cfg_addr,
  input  logic [LEN_W-1:0]         cfg_len,
  input  logic [NODE_W-1:0]        cfg_owner,
  output logic                     mtick,
  output logic [GT_W-1:0]          gtime,
  output logic                     gt_ovf,
  output logic                     slot_start,
  output logic                     tx_window,
  output logic [SW-1:0]            slot_idx,
  output logic [RW-1:0]            round_idx
);
  logic          wrap;
  logic [AW-1:0] addr_cur, addr_nxt;
  slot_ent_t     cur_ent, nxt_ent, wr_ent;

  assign wr_ent = '{len: cfg_len, owner: cfg_owner};

  tdma_mtick_gen #(.PERIOD(MT_PERIOD), .CORR_W(CORR_W)) u_mtick (
    .clk(clk), .rst(rst), .en(en), .corr_req(corr_req), .corr_val(corr_val),
    .wrap(wrap), .mtick(mtick)
  );

  tdma_gtime #(.GT_W(GT_W)) u_gtime (
    .clk(clk), .rst(rst), .wrap(wrap), .gtime(gtime), .ovf(gt_ovf)
  );

  tdma_slot_table #(.DEPTH(DEPTH)) u_table (
    .clk(clk), .rst(rst), .en(en), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_ent(wr_ent), .rd_a(addr_cur), .rd_b(addr_nxt),
    .ent_a(cur_ent), .ent_b(nxt_ent)
  );

  tdma_slot_seq #(.SLOTS(SLOTS), .ROUNDS(ROUNDS)) u_seq (
    .clk(clk), .rst(rst), .wrap(wrap), .node_id(node_id),
    .cur_ent(cur_ent), .nxt_ent(nxt_ent), .addr_cur(addr_cur),
    .addr_nxt(addr_nxt), .slot_start(slot_start), .tx_win(tx_window),
    .slot_idx(slot_idx), .round_idx(round_idx)
  );

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(gtime) && !mtick && !slot_start);

  assert_start_with_tick_R5: assert property (@(posedge clk) disable iff (rst)
    slot_start |-> mtick);
endmodule

// File: tb/tdma_timebase_test.sv
module tdma_timebase_test;
  import tdma_pkg::*;

  localparam int PER = 20, CW = 5, GW = 8, NS = 4, NR = 2, DEP = 8, NODE = 3;

  logic                 clk = 1'b0, rst = 1'b1, en = 1'b0;
  logic                 corr_req = 1'b0;
  logic signed [CW-1:0] corr_val = '0;
  logic                 cfg_we = 1'b0;
  logic [2:0]           cfg_addr = '0;
  logic [LEN_W-1:0]     cfg_len = '0;
  logic [NODE_W-1:0]    cfg_owner = '0;
  logic [NODE_W-1:0]    node_id = NODE_W'(NODE);
  logic                 mtick, gt_ovf, slot_start, tx_window;
  logic [GW-1:0]        gtime;
  logic [1:0]           slot_idx;
  logic [0:0]           round_idx;

  tdma_timebase #(.MT_PERIOD(PER), .CORR_W(CW), .GT_W(GW), .SLOTS(NS), .ROUNDS(NR)) uut (
    .clk(clk), .rst(rst), .en(en), .node_id(node_id), .corr_req(corr_req),
    .corr_val(corr_val), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_len(cfg_len),
    .cfg_owner(cfg_owner), .mtick(mtick), .gtime(gtime), .gt_ovf(gt_ovf),
    .slot_start(slot_start), .tx_window(tx_window), .slot_idx(slot_idx),
    .round_idx(round_idx)
  );

  always #2.5 clk = ~clk;

  typedef struct { int gt; int sl; int rd; int tx; } exp_t;
  exp_t q[$];
  exp_t e_mon;
  int lens[DEP] = '{3, 2, 4, 1, 2, 3, 1, 5};
  int owns[DEP] = '{1, 2, 3, 4, 3, 1, 2, 0};

  int n_cmp = 0, n_bad = 0, ovf_seen = 0, last_gt = 0;
  bit mon_on = 0, done = 0, prev_ovf = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver: expected slot starts from the table (R5 R6 R7)
  task automatic push_sched(input int nslots);
    int gt = 1;
    for (int k = 0; k < nslots; k++) begin
      int idx = k % DEP;
      exp_t it;
      it.gt = gt; it.sl = idx % NS; it.rd = idx / NS;
      it.tx = (owns[idx] == NODE) ? 1 : 0;
      q.push_back(it);
      gt = (gt + lens[idx]) % (1 << GW);
    end
  endtask

  // monitor: scoreboard compare away from the active edge
  always @(negedge clk) begin
    if (mon_on) begin
      if (slot_start) begin
        if (q.size() == 0) chk("R5", "unexpected slot start", 1, 0);
        else begin
          e_mon = q.pop_front();
          chk("R5", "gtime at slot start", int'(gtime), e_mon.gt);
          chk("R6", "slot index", int'(slot_idx), e_mon.sl);
          chk("R6", "round index", int'(round_idx), e_mon.rd);
          chk("R7", "tx window", int'(tx_window), e_mon.tx);
        end
      end
      if (mtick) begin
        chk("R3", "gtime step", int'(gtime), (last_gt + 1) % (1 << GW));
        last_gt = int'(gtime);
      end
      if (gt_ovf) begin
        ovf_seen++;
        chk("R4", "gtime at overflow", int'(gtime), 0);
        chk("R4", "overflow width", int'(prev_ovf), 0);
      end
      prev_ovf = gt_ovf;
    end
  end

  task automatic interval(output int cyc);
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!mtick);
  endtask

  task automatic corr_test(input int v1, input int v2, input bit two, input int dly);
    int c;
    do @(negedge clk); while (!mtick);
    repeat (dly) @(negedge clk);
    corr_req = 1'b1; corr_val = CW'(v1);
    @(negedge clk);
    if (two) begin
      corr_req = 1'b0;
      @(negedge clk);
      corr_req = 1'b1; corr_val = CW'(v2);
      @(negedge clk);
    end
    corr_req = 1'b0;
    while (!mtick) @(negedge clk);
    interval(c);
    chk("R2", "corrected macrotick", c, PER + (two ? v2 : v1));
    interval(c);
    chk("R2", "macrotick after correction", c, PER);
  endtask

  initial begin
    int c, g, bad;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < DEP; i++) begin
      cfg_we = 1'b1; cfg_addr = 3'(i); cfg_len = LEN_W'(lens[i]); cfg_owner = NODE_W'(owns[i]);
      @(negedge clk);
    end
    cfg_we = 1'b0;
    @(negedge clk);
    chk("R10", "reset mtick", int'(mtick), 0);
    chk("R10", "reset gtime", int'(gtime), 0);
    chk("R10", "reset overflow", int'(gt_ovf), 0);
    chk("R10", "reset slot start", int'(slot_start), 0);
    chk("R10", "reset tx window", int'(tx_window), 0);
    chk("R10", "reset indices", int'(slot_idx) + int'(round_idx), 0);

    push_sched(104);
    mon_on = 1'b1;
    en = 1'b1;
    interval(c);
    chk("R1", "first macrotick after enable", c, PER);
    interval(c);
    chk("R1", "macrotick period", c, PER);

    corr_test(3, 0, 1'b0, 5);
    corr_test(-4, 0, 1'b0, 19);
    corr_test(5, -3, 1'b1, 4);

    // R8: a write while running must not change the schedule
    cfg_we = 1'b1; cfg_addr = 3'd0; cfg_len = LEN_W'(9); cfg_owner = NODE_W'(NODE);
    @(negedge clk);
    cfg_we = 1'b0;

    // R9: hold while disabled, mid slot
    repeat (7) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    g = int'(gtime);
    bad = 0;
    repeat (40) begin
      @(negedge clk);
      if (mtick || slot_start || int'(gtime) != g) bad++;
    end
    chk("R9", "activity while disabled", bad, 0);
    en = 1'b1;

    while (q.size() != 0) @(negedge clk);
    mon_on = 1'b0;
    chk("R4", "overflow count", ovf_seen, 1);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d (slot starts left)", q.size(), 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule